// File: doc/BRIEF.md
# AES3 Subframe Transmitter with Channel-Status Block Slaving

The block turns a stream of stereo audio samples into an AES3-style serial line. For each frame strobe it takes one left and one right 24-bit sample. It sends them as two 32-slot subframes. Each subframe carries a preamble, four auxiliary bits, twenty audio bits, and then validity, user, channel-status and parity. Everything after the preamble is biphase-mark coded. The preamble is one of three fixed half-cell patterns that break the coding rule. The line leaves the block on a complementary output pair.

A frame counter runs from 0 to 191 and marks the channel-status block. The left subframe of frame 0 carries the block-start preamble.

The block has two modes:
- **Normal mode.** The counter advances freely. The channel-status bit comes from a parallel channel-status word indexed by the frame number, and the user and validity bits are zero.
- **Pass-through mode.** The C, U and V bits supplied with each sample go out with that sample. An external block-start input, sampled on each frame strobe, re-aligns the counter to frame 0 on a low-to-high change. The master clock must then run at 256 times the sample rate instead of 128, so the block sends one half-cell every second clock.

Top module: `aes_sf_tx`

## Requirements
- R1: While rst_ni is low, txp_o is 0 and txn_o is 1. The first frame sent after reset is frame 0 of the block.
- R2: After reset, txn_o is always the complement of txp_o.
- R3: In slots 4 to 31, the first half-cell of every slot differs from the level before it. The second half-cell differs from the first for a one and equals it for a zero.
- R4: The preamble fills the 8 half-cells of slots 0 to 3, sent in this order: block start 11101000, left 11100010, right 11100100. These are the patterns when the level before the preamble is 0; when that level is 1 each half-cell is inverted.
- R5: Slots 4 to 7 carry sample bits 3..0 and slots 8 to 27 carry sample bits 23..4, both least significant bit first. Slot 28 is V, slot 29 is U and slot 30 is C.
- R6: Slot 31 makes the number of ones in slots 4 to 31 even.
- R7: In normal mode each fsync_i strobe moves the frame counter up by one, wrapping from 191 to 0. The left subframe of frame 0 uses the block-start preamble, and no other subframe does.
- R8: In normal mode C in both subframes equals cs_bits_i bit n for frame n below 24, and 0 for all later frames. U and V are 0, and the per-sample C, U and V inputs have no effect.
- R9: In pass-through mode, each subframe's C, U and V are the per-channel inputs captured with its sample on the strobe, and cs_bits_i has no effect.
- R10: In pass-through mode the counter goes to frame 0 only when blk_start_i was low at the previous pass-through strobe and is high at this one; otherwise it advances. The first pass-through strobe after reset or after normal mode never re-aligns it.
- R11: After the strobe edge the first half-cell appears at the next edge. Later half-cells follow every clock in normal mode and every second clock in pass-through mode. After 128 half-cells the line holds its level until the next strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock (128 or 256 times the sample rate) |
| rst_ni | input | 1 | Active-low asynchronous reset |
| fsync_i | input | 1 | One-cycle frame strobe; captures samples and starts a frame |
| passthru_i | input | 1 | 1 selects pass-through mode for the frame being captured |
| blk_start_i | input | 1 | External block-start level, sampled on the strobe |
| left_i | input | 24 | Left audio sample |
| right_i | input | 24 | Right audio sample |
| c_l_i | input | 1 | Left channel-status bit (pass-through) |
| u_l_i | input | 1 | Left user bit (pass-through) |
| v_l_i | input | 1 | Left validity bit (pass-through) |
| c_r_i | input | 1 | Right channel-status bit (pass-through) |
| u_r_i | input | 1 | Right user bit (pass-through) |
| v_r_i | input | 1 | Right validity bit (pass-through) |
| cs_bits_i | input | 24 | Channel-status bits for frames 0 to 23 in normal mode |
| txp_o | output | 1 | Coded line, true side |
| txn_o | output | 1 | Coded line, complement side |

## Verification
A frame counter that slips or re-aligns wrongly shows up as the block-start preamble on the wrong frame. It also shows up as channel-status bits shifted against cs_bits_i. Both are visible within the frame that follows the bad strobe. A wrong captured level or polarity register breaks a coding transition or a preamble inside the current subframe. That appears as a decode error before the next preamble. A wrong captured field shows up as a parity or field mismatch in the subframe it belongs to.

// File: rtl/aes_sf_tx_pkg.sv
package aes_sf_tx_pkg;
  localparam int unsigned SLOTS          = 32;
  localparam int unsigned HALF_PER_SF    = 2 * SLOTS;
  localparam int unsigned HALF_PER_FRAME = 2 * HALF_PER_SF;
  localparam int unsigned HC_W           = $clog2(HALF_PER_FRAME);
  localparam int unsigned SAMPLE_W       = 24;
  localparam int unsigned AUX_W          = 4;
  // slot positions fixed by the line format
  localparam int unsigned SLOT_AUX = 4;
  localparam int unsigned SLOT_AUD = SLOT_AUX + AUX_W;
  localparam int unsigned SLOT_V   = SLOT_AUD + SAMPLE_W - AUX_W;
  localparam int unsigned SLOT_U   = SLOT_V + 1;
  localparam int unsigned SLOT_C   = SLOT_U + 1;
  localparam int unsigned SLOT_P   = SLOT_C + 1;

  typedef enum logic [1:0] {PRE_X, PRE_Y, PRE_Z} pre_e;

  typedef struct packed {
    logic c;
    logic u;
    logic v;
  } cuv_t;

  // half-cell patterns, MSB sent first, for a preceding level of 0
  function automatic logic [7:0] pre_pat(input pre_e p);
    case (p)
      PRE_Z:   return 8'b1110_1000;
      PRE_Y:   return 8'b1110_0100;
      default: return 8'b1110_0010;
    endcase
  endfunction
endpackage

// File: rtl/aes_blk_ctr.sv
module aes_blk_ctr #(
  parameter int unsigned FRAMES = 192,
  localparam int unsigned FW = $clog2(FRAMES)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          strobe_i,
  input  logic          slave_i,
  input  logic          blk_i,
  output logic [FW-1:0] frame_o
);
  logic [FW-1:0] frame_q;
  logic          prev_q;
  logic          realign;

  assign realign = slave_i && !prev_q && blk_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      frame_q <= FW'(FRAMES - 1);
      prev_q  <= 1'b1;
    end else if (strobe_i) begin
      if (realign || frame_q == FW'(FRAMES - 1)) frame_q <= '0;
      else                                       frame_q <= frame_q + 1'b1;
      // outside pass-through the history reads as high: no edge on entry
      prev_q <= slave_i ? blk_i : 1'b1;
    end
  end

  assign frame_o = frame_q;
endmodule

// File: rtl/aes_sf_build.sv
module aes_sf_build
  import aes_sf_tx_pkg::*;
(
  input  logic [SAMPLE_W-1:0] sample_i,
  input  cuv_t                cuv_i,
  output logic [SLOTS-1:0]    word_o
);
  logic [SLOTS-1:0] w;

  always_comb begin
    w = '0;
    w[SLOT_AUD-1:SLOT_AUX] = sample_i[AUX_W-1:0];
    w[SLOT_V-1:SLOT_AUD]   = sample_i[SAMPLE_W-1:AUX_W];
    w[SLOT_V] = cuv_i.v;
    w[SLOT_U] = cuv_i.u;
    w[SLOT_C] = cuv_i.c;
    w[SLOT_P] = ^w[SLOT_C:SLOT_AUX];
  end

  assign word_o = w;
endmodule

// File: rtl/aes_bmc_ser.sv
module aes_bmc_ser
  import aes_sf_tx_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             slow_i,
  input  logic             first_z_i,
  input  logic [SLOTS-1:0] word_l_i,
  input  logic [SLOTS-1:0] word_r_i,
  output logic             txp_o,
  output logic             txn_o,
  output logic             emit_o,
  output logic [HC_W-1:0]  hc_o
);
  logic [HC_W-1:0] hc_q;
  logic            active_q, div_q, line_q, nline_q, pol_q;
  logic            tick, emit, sub, half, in_pre, pol, lvl;
  logic [4:0]      slot;
  logic [2:0]      pidx;
  logic [SLOTS-1:0] word;
  logic [7:0]      pat;

  assign tick   = !slow_i || !div_q;
  assign emit   = active_q && tick;
  assign sub    = hc_q[HC_W-1];
  assign slot   = hc_q[HC_W-2:1];
  assign half   = hc_q[0];
  assign pidx   = hc_q[2:0];
  assign in_pre = (slot < 5'd4);
  assign word   = sub ? word_r_i : word_l_i;
  assign pat    = pre_pat(sub ? PRE_Y : (first_z_i ? PRE_Z : PRE_X));
  assign pol    = (pidx == 3'd0) ? line_q : pol_q;

  always_comb begin
    if (in_pre)     lvl = pat[~pidx] ^ pol;
    else if (!half) lvl = ~line_q;
    else            lvl = line_q ^ word[slot];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hc_q     <= '0;
      active_q <= 1'b0;
      div_q    <= 1'b0;
      line_q   <= 1'b0;
      nline_q  <= 1'b1;
      pol_q    <= 1'b0;
    end else begin
      if (emit) begin
        line_q  <= lvl;
        nline_q <= ~lvl;
        if (in_pre && pidx == 3'd0) pol_q <= line_q;
      end
      if (start_i) begin
        hc_q     <= '0;
        active_q <= 1'b1;
        div_q    <= 1'b0;
      end else if (active_q) begin
        div_q <= ~div_q;
        if (tick) begin
          hc_q <= hc_q + 1'b1;
          if (hc_q == HC_W'(HALF_PER_FRAME - 1)) active_q <= 1'b0;
        end
      end
    end
  end

  assign txp_o  = line_q;
  assign txn_o  = nline_q;
  assign emit_o = emit;
  assign hc_o   = hc_q;
endmodule

// File: rtl/aes_sf_tx.sv
module aes_sf_tx
  import aes_sf_tx_pkg::*;
#(
  parameter int unsigned FRAMES = 192,
  parameter int unsigned CS_W   = 24
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                fsync_i,
  input  logic                passthru_i,
  input  logic                blk_start_i,
  input  logic [SAMPLE_W-1:0] left_i,
  input  logic [SAMPLE_W-1:0] right_i,
  input  logic                c_l_i,
  input  logic                u_l_i,
  input  logic                v_l_i,
  input  logic                c_r_i,
  input  logic                u_r_i,
  input  logic                v_r_i,
  input  logic [CS_W-1:0]     cs_bits_i,
  output logic                txp_o,
  output logic                txn_o
);
  localparam int unsigned FW = $clog2(FRAMES);

  logic                trn_q;
  logic [SAMPLE_W-1:0] smp_q [2];
  cuv_t                raw_q [2];
  logic [CS_W-1:0]     cs_q;
  logic [FW-1:0]       frame_w;
  logic                cs_bit;
  cuv_t                cuv_w [2];
  logic [SLOTS-1:0]    word_w [2];
  logic                emit_w;
  logic [HC_W-1:0]     hc_w;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      trn_q    <= 1'b0;
      smp_q[0] <= '0;
      smp_q[1] <= '0;
      raw_q[0] <= '0;
      raw_q[1] <= '0;
      cs_q     <= '0;
    end else if (fsync_i) begin
      trn_q    <= passthru_i;
      smp_q[0] <= left_i;
      smp_q[1] <= right_i;
      raw_q[0] <= cuv_t'{c: c_l_i, u: u_l_i, v: v_l_i};
      raw_q[1] <= cuv_t'{c: c_r_i, u: u_r_i, v: v_r_i};
      cs_q     <= cs_bits_i;
    end
  end

  aes_blk_ctr #(.FRAMES(FRAMES)) u_ctr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .strobe_i(fsync_i),
    .slave_i (passthru_i),
    .blk_i   (blk_start_i),
    .frame_o (frame_w)
  );

  always_comb begin
    cs_bit = 1'b0;
    for (int i = 0; i < int'(CS_W); i++)
      if (frame_w == FW'(i)) cs_bit = cs_q[i];
  end

  for (genvar ch = 0; ch < 2; ch++) begin : g_ch
    assign cuv_w[ch] = trn_q ? raw_q[ch] : cuv_t'{c: cs_bit, u: 1'b0, v: 1'b0};
    aes_sf_build u_build (
      .sample_i(smp_q[ch]),
      .cuv_i   (cuv_w[ch]),
      .word_o  (word_w[ch])
    );
  end

  aes_bmc_ser u_ser (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (fsync_i),
    .slow_i   (trn_q),
    .first_z_i(frame_w == '0),
    .word_l_i (word_w[0]),
    .word_r_i (word_w[1]),
    .txp_o    (txp_o),
    .txn_o    (txn_o),
    .emit_o   (emit_w),
    .hc_o     (hc_w)
  );
endmodule

// File: rtl/aes_sf_tx_chk.sv
module aes_sf_tx_chk
  import aes_sf_tx_pkg::*;
#(
  parameter int unsigned FRAMES = 192,
  localparam int unsigned FW = $clog2(FRAMES)
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            fsync_i,
  input logic            passthru_i,
  input logic            blk_start_i,
  input logic            txp_o,
  input logic            txn_o,
  input logic [FW-1:0]   frame_i,
  input logic            emit_i,
  input logic [HC_W-1:0] hc_i
);
  logic seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      seen_q <= 1'b1;
    else if (fsync_i) seen_q <= passthru_i ? blk_start_i : 1'b1;
  end

  a_r2_complement: assert property (@(posedge clk_i) disable iff (!rst_ni)
    txp_o != txn_o);

  a_r7_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_i < FW'(FRAMES));

  a_r7_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fsync_i && !passthru_i && frame_i == FW'(FRAMES - 1) |=> frame_i == '0);

  a_r10_realign: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fsync_i && passthru_i && !seen_q && blk_start_i |=> frame_i == '0);

  a_r10_advance: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fsync_i && passthru_i && !(!seen_q && blk_start_i) && frame_i != FW'(FRAMES - 1)
    |=> frame_i == $past(frame_i) + 1'b1);

  a_r3_slot_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    emit_i && hc_i[5:3] != 3'd0 && !hc_i[0] |=> txp_o != $past(txp_o));

  a_r11_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !emit_i |=> $stable(txp_o));
endmodule

bind aes_sf_tx aes_sf_tx_chk #(.FRAMES(FRAMES)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .fsync_i    (fsync_i),
  .passthru_i (passthru_i),
  .blk_start_i(blk_start_i),
  .txp_o      (txp_o),
  .txn_o      (txn_o),
  .frame_i    (frame_w),
  .emit_i     (emit_w),
  .hc_i       (hc_w)
);

// File: tb/sim_aes_sf_tx.sv
`timescale 1ns/1ps
module sim_aes_sf_tx;
  logic clk = 1'b0, rst_n = 1'b0;
  logic fsync = 0, pt = 0, blk = 0;
  logic [23:0] l_s = '0, r_s = '0, cs = '0;
  logic cl = 0, ul = 0, vl = 0, cr = 0, ur = 0, vr = 0;
  logic txp, txn;
  int checks = 0, fails = 0, cyc = 0;
  bit done = 0;
  logic prev_lvl;

  localparam logic [7:0] P_Z = 8'b1110_1000;
  localparam logic [7:0] P_X = 8'b1110_0010;
  localparam logic [7:0] P_Y = 8'b1110_0100;

  // {blk, left, {c,u,v} left, {c,u,v} right, expect block-start preamble}
  localparam logic [31:0] VEC [8] = '{
    {1'b1, 24'h123456, 3'b101, 3'b010, 1'b0},
    {1'b0, 24'hFEDCBA, 3'b111, 3'b000, 1'b0},
    {1'b1, 24'h000001, 3'b001, 3'b100, 1'b1},
    {1'b1, 24'h800000, 3'b010, 3'b011, 1'b0},
    {1'b0, 24'hA5A5A5, 3'b000, 3'b111, 1'b0},
    {1'b1, 24'h5A5A5A, 3'b100, 3'b001, 1'b1},
    {1'b0, 24'hFFFFFF, 3'b110, 3'b101, 1'b0},
    {1'b0, 24'h000000, 3'b011, 3'b110, 1'b0}
  };

  aes_sf_tx u0 (
    .clk_i(clk), .rst_ni(rst_n), .fsync_i(fsync), .passthru_i(pt),
    .blk_start_i(blk), .left_i(l_s), .right_i(r_s),
    .c_l_i(cl), .u_l_i(ul), .v_l_i(vl), .c_r_i(cr), .u_r_i(ur), .v_r_i(vr),
    .cs_bits_i(cs), .txp_o(txp), .txn_o(txn)
  );

  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
      finish_run();
    end
  end

  // called at a negedge; strobe hits the next posedge
  task automatic run_frame(input logic trn, input logic b, input logic [23:0] lv,
                           input logic [23:0] rv, input logic [2:0] cuv_l,
                           input logic [2:0] cuv_r, input logic ez,
                           input logic [2:0] e_l, input logic [2:0] e_r);
    logic hc [128];
    bit comp_ok = 1, mid_ok = 1;
    string mreq;
    pt = trn; blk = b; l_s = lv; r_s = rv;
    {cl, ul, vl} = cuv_l; {cr, ur, vr} = cuv_r;
    fsync = 1;
    @(negedge clk);
    fsync = 0;
    chk(txp == prev_lvl, "R11 early", {31'd0, txp}, {31'd0, prev_lvl});
    for (int i = 0; i < 128; i++) begin
      @(posedge clk); @(negedge clk);
      hc[i] = txp;
      if (txn != ~txp) comp_ok = 0;
      if (trn && i != 127) begin
        @(posedge clk); @(negedge clk);
        if (txp != hc[i]) mid_ok = 0;
      end
    end
    chk(comp_ok, "R2", {31'd0, comp_ok}, 32'd1);
    if (trn) chk(mid_ok, "R11 slow", {31'd0, mid_ok}, 32'd1);
    mreq = trn ? "R9" : "R8";
    for (int s = 0; s < 2; s++) begin
      logic [7:0] got, expp;
      logic [31:0] w;
      logic lastl, h0, h1;
      bit bm_ok;
      lastl = (s == 0) ? prev_lvl : hc[63];
      for (int j = 0; j < 8; j++) got[7-j] = hc[64*s+j];
      expp = ((s == 1) ? P_Y : (ez ? P_Z : P_X)) ^ {8{lastl}};
      if (s == 1)   chk(got == expp, "R4", {24'd0, got}, {24'd0, expp});
      else if (trn) chk(got == expp, "R10", {24'd0, got}, {24'd0, expp});
      else          chk(got == expp, "R7", {24'd0, got}, {24'd0, expp});
      lastl = hc[64*s+7];
      bm_ok = 1; w = '0;
      for (int k = 4; k < 32; k++) begin
        h0 = hc[64*s+2*k]; h1 = hc[64*s+2*k+1];
        if (h0 == lastl) bm_ok = 0;
        w[k] = h0 ^ h1;
        lastl = h1;
      end
      chk(bm_ok, "R3", {31'd0, bm_ok}, 32'd1);
      chk({w[27:8], w[7:4]} == ((s == 0) ? lv : rv), "R5",
          {8'd0, w[27:8], w[7:4]}, {8'd0, (s == 0) ? lv : rv});
      chk(^w[31:4] == 1'b0, "R6", w, {31'd0, ^w[31:4]});
      chk({w[30], w[29], w[28]} == ((s == 0) ? e_l : e_r), mreq,
          {29'd0, w[30], w[29], w[28]}, {29'd0, (s == 0) ? e_l : e_r});
    end
    prev_lvl = hc[127];
  endtask

  initial begin
    logic [23:0] a;
    int fi;
    prev_lvl = 0;
    repeat (3) @(negedge clk);
    chk(txp == 1'b0 && txn == 1'b1, "R1 reset", {30'd0, txp, txn}, 32'b01);
    rst_n = 1;
    @(negedge clk);
    cs = 24'hB53CE1;
    // normal mode: free-running counter across a wrap; per-sample bits ignored
    for (int f = 0; f < 194; f++) begin
      fi = f % 192;
      a = {f[7:0], 16'hA5C3} ^ {3{f[7:0]}};
      run_frame(1'b0, f[0], a, ~a ^ 24'(f), 3'b111, 3'b111, fi == 0,
                {(fi < 24) ? cs[fi] : 1'b0, 2'b00},
                {(fi < 24) ? cs[fi] : 1'b0, 2'b00});
    end
    // line holds after a completed frame
    a = {23'd0, txp};
    repeat (3) @(negedge clk);
    chk(txp == a[0], "R11 idle", {31'd0, txp}, a);
    // pass-through table; channel-status word must have no effect
    cs = 24'hFFFFFF;
    for (int v = 0; v < 8; v++) begin
      run_frame(1'b1, VEC[v][31], VEC[v][30:7], ~VEC[v][30:7], VEC[v][6:4], VEC[v][3:1],
                VEC[v][0], VEC[v][6:4], VEC[v][3:1]);
    end
    // reset mid-run, then block must restart at frame 0
    rst_n = 0;
    @(negedge clk);
    chk(txp == 1'b0 && txn == 1'b1, "R1 mid reset", {30'd0, txp, txn}, 32'b01);
    rst_n = 1; prev_lvl = 0; cs = 24'h000001;
    @(negedge clk);
    run_frame(1'b0, 1'b0, 24'h0F0F0F, 24'hF0F0F0, 3'b000, 3'b000, 1'b1, 3'b100, 3'b100);
    run_frame(1'b0, 1'b0, 24'h0F0F0F, 24'hF0F0F0, 3'b000, 3'b000, 1'b0, 3'b000, 3'b000);
    finish_run();
  end
endmodule